// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits next to the execute stage of a five-stage in-order integer pipeline. For each of the two ALU operands it looks at the source register number of the instruction in execute. It compares that number with the destination register numbers held in the two later pipeline registers: the one between execute and memory, and the one between memory and writeback. It then decides where the operand value should come from. There are three choices: the register-file read value, the result held in the memory stage, or the value being written back.

The block outputs a 2-bit select code for each operand and the selected operand data. The A operand goes straight to the ALU. The B operand goes on to an immediate-select multiplexer that is outside this block. A later stage is used as a source only if it writes a register and its destination is not register zero. When both later stages qualify, the younger instruction's result is used. The whole block is combinational and has no clock or storage.

Top module: `fwd_unit`

## Requirements
- R1: When no later stage qualifies as a source, the operand select is 2'b00 and the operand output equals the register-file value for that operand.
- R2: When the memory stage has its write bit set, its destination is non-zero, and its destination equals the operand's source register, the select is 2'b10 and the operand output equals the memory-stage result.
- R3: When the writeback stage has its write bit set, its destination is non-zero and equals the operand's source register, and the memory stage does not qualify, the select is 2'b01 and the operand output equals the writeback value.
- R4: When both later stages qualify for the same operand, the memory stage (the younger producer) wins: select 2'b10, memory-stage result. This also covers two back-to-back writes to one register.
- R5: A destination of register 0 never causes forwarding, even when the write bit is set and the source register is also 0.
- R6: A stage whose write bit is clear never causes forwarding, even when its destination matches the source register.
- R7: Operand A is decided only from the first source field and operand B only from the second source field, using the same rules. The two operands can select different sources in the same cycle.
- R8: If the memory stage's destination equals the source register but that stage does not qualify (write bit clear or destination 0), it does not block forwarding from a qualifying writeback stage.
- R9: The selects and operand outputs follow the inputs combinationally, with no clock edge between a change on an input and the matching change on an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | 5 | First source register of the instruction in execute |
| ex_src_b_i | input | 5 | Second source register of the instruction in execute |
| mem_dst_i | input | 5 | Destination register held in the memory stage |
| mem_wr_i | input | 1 | Memory-stage register-write bit |
| wb_dst_i | input | 5 | Destination register held in the writeback stage |
| wb_wr_i | input | 1 | Writeback-stage register-write bit |
| rf_a_i | input | 32 | Register-file value for operand A |
| rf_b_i | input | 32 | Register-file value for operand B |
| mem_res_i | input | 32 | Result held in the memory stage |
| wb_val_i | input | 32 | Value being written back |
| sel_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| sel_b_o | output | 2 | Operand B select, same encoding |
| opnd_a_o | output | 32 | Selected operand A to the ALU |
| opnd_b_o | output | 32 | Selected operand B to the immediate-select mux |

## Verification
Every result of this block is due in the same cycle as its stimulus: no register lies between any input and any output. The bench therefore changes inputs on the falling clock edge, waits 2 ns for the combinational paths to settle, and samples well before the next rising edge. For R9, the bench also changes inputs in the middle of a cycle and samples 1 ns later, so no clock edge falls between the change and the sample.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,
    SEL_WB   = 2'b01,
    SEL_MEM  = 2'b10,
    SEL_RSVD = 2'b11
  } fwd_sel_e;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_hit.sv
`timescale 1ns/1ps
// Qualifies one producing stage against one source register.
module fwd_hit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              wr_i,
  output logic              hit_o
);
  logic dst_nz;
  assign dst_nz = |dst_i;
  assign hit_o  = wr_i & dst_nz & (dst_i == src_i);
endmodule

// File: rtl/fwd_prio.sv
`timescale 1ns/1ps
// Younger stage first.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     mem_hit_i,
  input  logic     wb_hit_i,
  output fwd_sel_e sel_o
);
  always_comb begin
    if (mem_hit_i)     sel_o = SEL_MEM;
    else if (wb_hit_i) sel_o = SEL_WB;
    else               sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
`timescale 1ns/1ps
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] wb_i,
  output logic [DATA_W-1:0] out_o
);
  always_comb begin
    case (sel_i)
      SEL_MEM: out_o = mem_i;
      SEL_WB:  out_o = wb_i;
      default: out_o = rf_i; // reserved code falls back to register file
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_AW-1:0] ex_src_a_i,
  input  logic [REG_AW-1:0] ex_src_b_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wr_i,
  input  logic [REG_AW-1:0] wb_dst_i,
  input  logic              wb_wr_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [DATA_W-1:0] mem_res_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);
  logic [REG_AW-1:0] src    [NUM_OPND];
  logic [DATA_W-1:0] rf_val [NUM_OPND];
  logic [DATA_W-1:0] opnd   [NUM_OPND];
  fwd_sel_e          sel    [NUM_OPND];

  assign src[0]    = ex_src_a_i;
  assign src[1]    = ex_src_b_i;
  assign rf_val[0] = rf_a_i;
  assign rf_val[1] = rf_b_i;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    logic mem_hit, wb_hit;

    fwd_hit #(.REG_AW(REG_AW)) u_mem_hit (
      .src_i(src[i]), .dst_i(mem_dst_i), .wr_i(mem_wr_i), .hit_o(mem_hit)
    );
    fwd_hit #(.REG_AW(REG_AW)) u_wb_hit (
      .src_i(src[i]), .dst_i(wb_dst_i), .wr_i(wb_wr_i), .hit_o(wb_hit)
    );
    fwd_prio u_prio (
      .mem_hit_i(mem_hit), .wb_hit_i(wb_hit), .sel_o(sel[i])
    );
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i(sel[i]), .rf_i(rf_val[i]), .mem_i(mem_res_i),
      .wb_i(wb_val_i), .out_o(opnd[i])
    );
  end

  assign sel_a_o  = sel[0];
  assign sel_b_o  = sel[1];
  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
`timescale 1ns/1ps
module fwd_unit_chk #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic [REG_AW-1:0] ex_src_a_i,
  input logic [REG_AW-1:0] ex_src_b_i,
  input logic [REG_AW-1:0] mem_dst_i,
  input logic              mem_wr_i,
  input logic [REG_AW-1:0] wb_dst_i,
  input logic              wb_wr_i,
  input logic [DATA_W-1:0] rf_a_i,
  input logic [DATA_W-1:0] rf_b_i,
  input logic [DATA_W-1:0] mem_res_i,
  input logic [DATA_W-1:0] wb_val_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [DATA_W-1:0] opnd_a_o,
  input logic [DATA_W-1:0] opnd_b_o
);
  always_comb begin
    // operand A
    p_sel_legal_a_r1: assert (sel_a_o != 2'b11) else $error("A select reserved");
    p_rf_pass_a_r1: assert (sel_a_o != 2'b00 || opnd_a_o == rf_a_i)
      else $error("A rf mismatch");
    p_mem_data_a_r2: assert (sel_a_o != 2'b10 || opnd_a_o == mem_res_i)
      else $error("A mem mismatch");
    p_wb_data_a_r3: assert (sel_a_o != 2'b01 || opnd_a_o == wb_val_i)
      else $error("A wb mismatch");
    p_newest_a_r4: assert (sel_a_o != 2'b01 ||
                           !(mem_wr_i && mem_dst_i != '0 && mem_dst_i == ex_src_a_i))
      else $error("A older stage chosen");
    p_no_r0_a_r5: assert (ex_src_a_i != '0 || sel_a_o == 2'b00)
      else $error("A forwarded r0");
    p_no_wr_a_r6: assert (mem_wr_i || wb_wr_i || sel_a_o == 2'b00)
      else $error("A forwarded without write");
    // operand B
    p_sel_legal_b_r1: assert (sel_b_o != 2'b11) else $error("B select reserved");
    p_rf_pass_b_r1: assert (sel_b_o != 2'b00 || opnd_b_o == rf_b_i)
      else $error("B rf mismatch");
    p_mem_data_b_r2: assert (sel_b_o != 2'b10 || opnd_b_o == mem_res_i)
      else $error("B mem mismatch");
    p_wb_data_b_r3: assert (sel_b_o != 2'b01 || opnd_b_o == wb_val_i)
      else $error("B wb mismatch");
    p_newest_b_r4: assert (sel_b_o != 2'b01 ||
                           !(mem_wr_i && mem_dst_i != '0 && mem_dst_i == ex_src_b_i))
      else $error("B older stage chosen");
    p_no_r0_b_r5: assert (ex_src_b_i != '0 || sel_b_o == 2'b00)
      else $error("B forwarded r0");
    p_no_wr_b_r6: assert (mem_wr_i || wb_wr_i || sel_b_o == 2'b00)
      else $error("B forwarded without write");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] RF_A = 32'hA1A1_0001;
  localparam logic [DW-1:0] RF_B = 32'hB2B2_0002;
  localparam logic [DW-1:0] MEMV = 32'hCCCC_0003;
  localparam logic [DW-1:0] WBV  = 32'hDDDD_0004;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] src_a, src_b, mdst, wdst;
  logic          mwr, wwr;
  logic [DW-1:0] rfa, rfb, memv, wbv;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opa, opb;

  int total = 0;
  int bad   = 0;

  fwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut (
    .ex_src_a_i(src_a), .ex_src_b_i(src_b),
    .mem_dst_i(mdst), .mem_wr_i(mwr),
    .wb_dst_i(wdst), .wb_wr_i(wwr),
    .rf_a_i(rfa), .rf_b_i(rfb), .mem_res_i(memv), .wb_val_i(wbv),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(opa), .opnd_b_o(opb)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // sel code: 0 rf, 1 wb, 2 mem
  task automatic chk_both(input string req, input logic [1:0] ea, input logic [1:0] eb);
    logic [DW-1:0] da, db;
    da = (ea == 2'b10) ? memv : (ea == 2'b01) ? wbv : rfa;
    db = (eb == 2'b10) ? memv : (eb == 2'b01) ? wbv : rfb;
    chk(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk(req, "opnd_a", opa, da);
    chk(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk(req, "opnd_b", opb, db);
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic [AW-1:0] md, input logic mw,
                       input logic [AW-1:0] wd, input logic ww);
    @(negedge clk);
    src_a = a; src_b = b; mdst = md; mwr = mw; wdst = wd; wwr = ww;
    #2;
  endtask

  function automatic logic [1:0] model(input logic [AW-1:0] s,
                                       input logic [AW-1:0] md, input logic mw,
                                       input logic [AW-1:0] wd, input logic ww);
    if (mw && md != 0 && md == s)      return 2'b10;
    else if (ww && wd != 0 && wd == s) return 2'b01;
    else                               return 2'b00;
  endfunction

  task automatic t_reset;
    #2;
    chk_both("R1", 2'b00, 2'b00);
  endtask

  task automatic t_no_match;
    drive(5'd3, 5'd4, 5'd7, 1'b1, 5'd9, 1'b1);
    chk_both("R1", 2'b00, 2'b00);
  endtask

  task automatic t_mem_fwd;
    drive(5'd2, 5'd5, 5'd2, 1'b1, 5'd9, 1'b0);
    chk_both("R2", 2'b10, 2'b00);
    drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd0, 1'b0);
    chk_both("R2", 2'b10, 2'b10);
  endtask

  task automatic t_wb_fwd;
    drive(5'd1, 5'd6, 5'd11, 1'b1, 5'd6, 1'b1);
    chk_both("R3", 2'b00, 2'b01);
  endtask

  task automatic t_newest;
    drive(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);
    chk_both("R4", 2'b10, 2'b10);
    drive(5'd20, 5'd3, 5'd20, 1'b1, 5'd20, 1'b1);
    chk_both("R4", 2'b10, 2'b00);
  endtask

  task automatic t_reg_zero;
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk_both("R5", 2'b00, 2'b00);
  endtask

  task automatic t_no_write;
    drive(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0);
    chk_both("R6", 2'b00, 2'b00);
  endtask

  task automatic t_indep;
    drive(5'd10, 5'd12, 5'd12, 1'b1, 5'd10, 1'b1);
    chk_both("R7", 2'b01, 2'b10);
  endtask

  task automatic t_shadow;
    drive(5'd13, 5'd2, 5'd13, 1'b0, 5'd13, 1'b1);
    chk_both("R8", 2'b01, 2'b00);
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk_both("R8", 2'b00, 2'b00);
  endtask

  task automatic t_comb;
    @(posedge clk);
    #2;
    src_a = 5'd17; src_b = 5'd18; mdst = 5'd17; mwr = 1'b1; wdst = 5'd18; wwr = 1'b1;
    memv = 32'h1234_5678;
    #1;
    chk_both("R9", 2'b10, 2'b01);
    wbv = 32'h8765_4321;
    #1;
    chk("R9", "opnd_b", opb, 32'h8765_4321);
    memv = MEMV; wbv = WBV;
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a, b, md, wd;
      logic mw, ww;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a  = {3'b000, lfsr[1:0]};
      b  = {3'b000, lfsr[3:2]};
      md = {3'b000, lfsr[5:4]};
      wd = {3'b000, lfsr[7:6]};
      mw = lfsr[8];
      ww = lfsr[9];
      drive(a, b, md, mw, wd, ww);
      chk_both("R4", model(a, md, mw, wd, ww), model(b, md, mw, wd, ww));
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    src_a = '0; src_b = '0; mdst = '0; mwr = 1'b0; wdst = '0; wwr = 1'b0;
    rfa = RF_A; rfb = RF_B; memv = MEMV; wbv = WBV;
    t_reset();
    #20 rst_ni = 1'b1;
    t_no_match();
    t_mem_fwd();
    t_wb_fwd();
    t_newest();
    t_reg_zero();
    t_no_write();
    t_indep();
    t_shadow();
    t_comb();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule